// File: doc/BRIEF.md
# Dual-Ended Context Window Allocator

This block hands out register-file context windows for a small CPU that has no stack. Each window is a fixed group of registers in one on-chip RAM and holds the general registers, the flags and the program counter of one context. Switching context means pointing the CPU at a different window. No state is copied anywhere, and the program counter changes together with the rest of the window.

One pool of windows is shared from both ends. Subroutine calls made in normal context take windows upward from the bottom. Window 0 is the permanent base context. Interrupt entry takes windows downward from the top of the pool, and calls made inside the interrupt handler continue downward below the handler's own window. Interrupts do not nest. When the next allocation would make the two regions meet, a sticky trap is raised and nothing is allocated.

The block outputs the active window, its RAM base address, and the physical RAM address for the register index the CPU presents. A return for which nothing is allocated raises a one-cycle underflow flag.

Top module: `ctxw_alloc`

## Requirements
- R1: After a synchronous active-low reset, active_win is 0, in_irq is 0, trap is 0 and underflow is 0.
- R2: win_base equals active_win × REGS (8 by default) and reg_addr equals win_base + reg_idx, combinationally in the same cycle.
- R3: Outside an interrupt, an accepted call_req allocates the window one above the current topmost call window (the first call takes window 1). That window becomes active in the next cycle.
- R4: When no interrupt window is held, irq_req allocates the highest free window from the top (window 15 by default). In the next cycle that window is active and in_irq is 1.
- R5: irq_req is ignored while in_irq is 1.
- R6: A call accepted while in_irq is 1 allocates the window directly below the lowest window of the top region, and that window becomes active.
- R7: ret_call frees the most recently allocated call window of the current region, and the previously active window becomes active again.
- R8: ret_irq, when in_irq is 1, frees the interrupt window and every call window nested under it. in_irq drops, and the topmost bottom-region window (or window 0) becomes active.
- R9: If irq_req is accepted in the same cycle as call_req, the interrupt is taken first and the call is carried out in the following cycle inside the interrupt region. In that following cycle all other request inputs except trap_ack are ignored.
- R10: A call or interrupt entry when no free window lies between the two regions (the bottom region's top index has reached the top region's lowest free index) sets trap and leaves the active window and both regions unchanged.
- R11: trap stays at 1 until trap_ack is sampled at 1 in a cycle with no new trap cause.
- R12: ret_call with no call window in the current region, or ret_irq outside an interrupt, makes underflow 1 for exactly the next cycle and changes no window.
- R13: At most one of call_req, ret_call and ret_irq is active in a cycle. irq_req may coincide with any of them. Among simultaneous requests the order is: a held call first, then an accepted irq_req, then ret_irq, then ret_call, then call_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Subroutine call: allocate a call window |
| ret_call | input | 1 | Return from subroutine: free the newest call window |
| irq_req | input | 1 | Interrupt entry request |
| ret_irq | input | 1 | Return from interrupt |
| trap_ack | input | 1 | Clears a pending trap |
| reg_idx | input | 3 | Register index within the active window |
| active_win | output | 4 | Index of the active window |
| win_base | output | 7 | RAM address of register 0 of the active window |
| reg_addr | output | 7 | RAM address of reg_idx in the active window |
| in_irq | output | 1 | An interrupt window is held |
| trap | output | 1 | Sticky collision trap |
| underflow | output | 1 | One-cycle flag for a return with nothing to free |

## Verification
A corrupted pointer shows at the ports in the cycle after the edge that corrupts it. It appears as a wrong active_win and therefore wrong win_base and reg_addr, because the active window is derived directly from the two region pointers. A boundary error that is off by one stays hidden until the pool is nearly full or a region is empty. For that reason the bench drives both regions to collision and both to underflow, and compares every output against a queue-based model on every clock. A lost held call appears as a missing window one cycle after a simultaneous call and interrupt.

// File: rtl/ctxw_pkg.sv
// Package: shared request-operation encoding for the context window allocator.
// Assumes: one operation is performed per clock cycle.
package ctxw_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_CALL  = 3'd1,
        OP_IRQ   = 3'd2,
        OP_RCALL = 3'd3,
        OP_RIRQ  = 3'd4
    } ctxw_op_e;
endpackage

// File: rtl/ctxw_arbiter.sv
// Module: picks the single operation performed this cycle and holds a call
// that coincided with an accepted interrupt entry until the next cycle.
// Assumes: the caller presents at most one of call/ret_call/ret_irq at once.
module ctxw_arbiter
    import ctxw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     call_req,
    input  logic     ret_call,
    input  logic     irq_req,
    input  logic     ret_irq,
    input  logic     in_irq,
    output ctxw_op_e op
);
    logic held_q;

    // Priority selection: held call, interrupt entry, returns, new call.
    always_comb begin
        if (held_q)                  op = OP_CALL;
        else if (irq_req && !in_irq) op = OP_IRQ;
        else if (ret_irq)            op = OP_RIRQ;
        else if (ret_call)           op = OP_RCALL;
        else if (call_req)           op = OP_CALL;
        else                         op = OP_NONE;
    end

    // Hold register for a call that lost to a same-cycle interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= (op == OP_IRQ) && call_req;
    end
endmodule

// File: rtl/ctxw_pointers.sv
// Module: the two region pointers, collision trap and underflow flag.
// bot_top is the topmost call window of the bottom region (0 = base only).
// irq_next is the next free window of the top region (NUM_WIN-1 = empty).
// Assumes: NUM_WIN >= 4.
module ctxw_pointers
    import ctxw_pkg::*;
#(
    parameter int NUM_WIN = 16,
    localparam int WW     = $clog2(NUM_WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctxw_op_e      op,
    input  logic          trap_ack,
    output logic [WW-1:0] active_win,
    output logic          in_irq,
    output logic          trap,
    output logic          underflow
);
    localparam logic [WW-1:0] TOP_W = WW'(NUM_WIN - 1);

    logic [WW-1:0] bot_top_q, irq_next_q;
    logic          has_room, isr_calls, trap_set;

    // Derived state: room between regions, nested ISR calls, active window.
    always_comb begin
        has_room   = bot_top_q < irq_next_q;
        in_irq     = irq_next_q != TOP_W;
        isr_calls  = irq_next_q < (TOP_W - WW'(1));
        active_win = in_irq ? irq_next_q + WW'(1) : bot_top_q;
        trap_set   = ((op == OP_CALL) || (op == OP_IRQ)) && !has_room;
    end

    // Region pointer updates for the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bot_top_q  <= '0;
            irq_next_q <= TOP_W;
            underflow  <= 1'b0;
        end else begin
            underflow <= 1'b0;
            unique case (op)
                OP_CALL: if (has_room) begin
                    if (in_irq) irq_next_q <= irq_next_q - WW'(1);
                    else        bot_top_q  <= bot_top_q + WW'(1);
                end
                OP_IRQ: if (has_room) irq_next_q <= irq_next_q - WW'(1);
                OP_RCALL: begin
                    if (in_irq) begin
                        if (isr_calls) irq_next_q <= irq_next_q + WW'(1);
                        else           underflow  <= 1'b1;
                    end else begin
                        if (bot_top_q != '0) bot_top_q <= bot_top_q - WW'(1);
                        else                 underflow <= 1'b1;
                    end
                end
                OP_RIRQ: begin
                    if (in_irq) irq_next_q <= TOP_W;
                    else        underflow  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Sticky trap: a new cause wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        trap <= 1'b0;
        else if (trap_set) trap <= 1'b1;
        else if (trap_ack) trap <= 1'b0;
    end
endmodule

// File: rtl/ctxw_addr.sv
// Module: maps the active window and a register index to RAM addresses.
// Assumes: REGS >= 2; a power-of-two REGS uses plain concatenation.
module ctxw_addr #(
    parameter int NUM_WIN = 16,
    parameter int REGS    = 8,
    localparam int WW     = $clog2(NUM_WIN),
    localparam int RW     = $clog2(REGS),
    localparam int AW     = $clog2(NUM_WIN * REGS)
) (
    input  logic [WW-1:0] active_win,
    input  logic [RW-1:0] reg_idx,
    output logic [AW-1:0] win_base,
    output logic [AW-1:0] reg_addr
);
    generate
        if ((1 << RW) == REGS) begin : g_pow2
            // Power-of-two window size: base is the index shifted up.
            always_comb begin
                win_base = AW'({active_win, {RW{1'b0}}});
                reg_addr = AW'({active_win, reg_idx});
            end
        end else begin : g_mul
            // Other window sizes: multiply and add.
            always_comb begin
                win_base = AW'(active_win) * AW'(REGS);
                reg_addr = win_base + AW'(reg_idx);
            end
        end
    endgenerate
endmodule

// File: rtl/ctxw_alloc.sv
// Module: top of the dual-ended context window allocator. Calls grow from the
// bottom of the window pool, interrupt entry and its calls grow from the top.
// Assumes: synchronous active-low reset; request inputs follow R13.
module ctxw_alloc
    import ctxw_pkg::*;
#(
    parameter int NUM_WIN = 16,
    parameter int REGS    = 8,
    localparam int WW     = $clog2(NUM_WIN),
    localparam int RW     = $clog2(REGS),
    localparam int AW     = $clog2(NUM_WIN * REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_req,
    input  logic          ret_call,
    input  logic          irq_req,
    input  logic          ret_irq,
    input  logic          trap_ack,
    input  logic [RW-1:0] reg_idx,
    output logic [WW-1:0] active_win,
    output logic [AW-1:0] win_base,
    output logic [AW-1:0] reg_addr,
    output logic          in_irq,
    output logic          trap,
    output logic          underflow
);
    ctxw_op_e op;

    ctxw_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_call(ret_call),
        .irq_req(irq_req), .ret_irq(ret_irq), .in_irq(in_irq), .op(op)
    );

    ctxw_pointers #(.NUM_WIN(NUM_WIN)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(op), .trap_ack(trap_ack),
        .active_win(active_win), .in_irq(in_irq), .trap(trap),
        .underflow(underflow)
    );

    ctxw_addr #(.NUM_WIN(NUM_WIN), .REGS(REGS)) u_addr (
        .active_win(active_win), .reg_idx(reg_idx),
        .win_base(win_base), .reg_addr(reg_addr)
    );
endmodule

// File: rtl/ctxw_alloc_chk.sv
// Checker: port-level properties of ctxw_alloc, attached by bind.
module ctxw_alloc_chk #(
    parameter int NUM_WIN = 16,
    parameter int REGS    = 8,
    localparam int WW     = $clog2(NUM_WIN),
    localparam int RW     = $clog2(REGS),
    localparam int AW     = $clog2(NUM_WIN * REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trap_ack,
    input logic [RW-1:0] reg_idx,
    input logic [WW-1:0] active_win,
    input logic [AW-1:0] win_base,
    input logic [AW-1:0] reg_addr,
    input logic          in_irq,
    input logic          trap,
    input logic          underflow
);
    p_addr_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == win_base + AW'(reg_idx));

    p_enter_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_irq) |-> active_win == WW'(NUM_WIN - 1));

    p_trap_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap) |-> $stable(active_win) && $stable(in_irq));

    p_trap_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap && !trap_ack |=> trap);

    p_underflow_still_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $stable(active_win) && $stable(in_irq));
endmodule

bind ctxw_alloc ctxw_alloc_chk #(.NUM_WIN(NUM_WIN), .REGS(REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .trap_ack(trap_ack), .reg_idx(reg_idx),
    .active_win(active_win), .win_base(win_base), .reg_addr(reg_addr),
    .in_irq(in_irq), .trap(trap), .underflow(underflow)
);

// File: tb/tb_ctxw_alloc.sv
// Bench: queue-based reference model of both window regions, compared on
// every clock against the design's outputs.
module tb_ctxw_alloc;
    localparam int NW = 16;
    localparam int RG = 8;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       call_req = 0, ret_call = 0, irq_req = 0, ret_irq = 0, trap_ack = 0;
    logic [2:0] reg_idx = '0;
    logic [3:0] active_win;
    logic [6:0] win_base, reg_addr;
    logic       in_irq, trap, underflow;

    int compared = 0, mismatched = 0;
    bit done = 0;

    ctxw_alloc dut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_call(ret_call),
        .irq_req(irq_req), .ret_irq(ret_irq), .trap_ack(trap_ack),
        .reg_idx(reg_idx), .active_win(active_win), .win_base(win_base),
        .reg_addr(reg_addr), .in_irq(in_irq), .trap(trap), .underflow(underflow)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Reference model: window numbers held in two queues.
    int bot_q[$];
    int top_q[$];
    bit m_trap, m_uf, m_held;

    function automatic int m_active();
        if (top_q.size() > 0) return top_q[$];
        if (bot_q.size() > 0) return bot_q[$];
        return 0;
    endfunction

    function automatic int m_free();
        return (NW - 1) - bot_q.size() - top_q.size();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bot_q.delete(); top_q.delete();
            m_trap = 0; m_uf = 0; m_held = 0;
        end else begin
            bit set_t, do_call, was_held;
            set_t = 0; do_call = 0;
            was_held = m_held;
            m_held = 0;
            m_uf = 0;
            if (was_held) do_call = 1;  // R9 held call goes first
            else if (irq_req && top_q.size() == 0) begin  // R4
                if (m_free() > 0) top_q.push_back(NW - 1);
                else set_t = 1;  // R10
                m_held = call_req;
            end else if (ret_irq) begin  // R8
                if (top_q.size() > 0) top_q.delete();
                else m_uf = 1;  // R12
            end else if (ret_call) begin  // R7
                if (top_q.size() > 0) begin
                    if (top_q.size() > 1) void'(top_q.pop_back());
                    else m_uf = 1;
                end else begin
                    if (bot_q.size() > 0) void'(bot_q.pop_back());
                    else m_uf = 1;
                end
            end else if (call_req) do_call = 1;
            if (do_call) begin
                if (m_free() == 0) set_t = 1;
                else if (top_q.size() > 0) top_q.push_back(top_q[$] - 1);  // R6
                else bot_q.push_back(bot_q.size() + 1);  // R3
            end
            if (set_t) m_trap = 1;
            else if (trap_ack) m_trap = 0;  // R11
        end
    end

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, well after the edge.
    always @(posedge clk) begin
        #5;
        if (!done) begin
            chk("R3 R6 R7 R8 active_win", int'(active_win), m_active());
            chk("R4 R5 in_irq", int'(in_irq), int'(top_q.size() > 0));
            chk("R10 R11 trap", int'(trap), int'(m_trap));
            chk("R12 underflow", int'(underflow), int'(m_uf));
            chk("R2 win_base", int'(win_base), m_active() * RG);
            chk("R2 reg_addr", int'(reg_addr), m_active() * RG + int'(reg_idx));
        end
    end

    task automatic step(bit c, bit i, bit rc, bit ri, bit ack);
        @(negedge clk);
        call_req = c; irq_req = i; ret_call = rc; ret_irq = ri; trap_ack = ack;
        reg_idx = reg_idx + 3'd3;
    endtask

    initial begin
        #4_000_000;
        mismatched++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) step(0, 0, 0, 0, 0);
        @(negedge clk) rst_n = 1'b1;  // R1 checked during and after reset
        step(0, 0, 0, 0, 0);
        // R3 three calls, R7 three returns, R12 one extra return
        repeat (3) step(1, 0, 0, 0, 0);
        repeat (4) step(0, 0, 1, 0, 0);
        // R4 entry, R5 second request ignored, R6 nested call
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);  // R12 only the ISR window is left
        step(0, 0, 0, 1, 0);  // R8
        step(0, 0, 0, 1, 0);  // R12 no interrupt held
        // R9 coincident call and interrupt entry
        repeat (2) step(1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        // R10 fill the pool until collision, R11 trap holds then clears
        repeat (15) step(1, 0, 0, 0, 0);
        repeat (3) step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0);  // R10 interrupt entry with a full pool
        step(0, 0, 0, 0, 1);
        repeat (16) step(0, 0, 1, 0, 0);
        // R13 mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = $urandom_range(0, 9);
            step(k < 4, $urandom_range(0, 5) == 0, k == 4 || k == 5, k == 6,
                 $urandom_range(0, 3) == 0);
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule